// File: doc/BRIEF.md
# MDIO Clause 45 Management Master

This block runs indirect-access management frames on a two-wire MDIO bus towards an external PHY. A host places an operation code, a 5-bit port address, a 5-bit device address and a 16-bit payload on the command inputs and pulses `start`. The block then produces the management clock by dividing the system clock and shifts the frame out through separate output-enable and output-data signals. On read frames it releases the line and collects the 16 data bits the PHY returns.

Every register access is made of separate frames. An address frame loads the register address into the PHY. A following write frame or read frame then acts on that register. Read frames release the line during the turnaround. Address and write frames drive the turnaround bits themselves. `busy` covers the whole transaction. `done` marks the moment the last data bit has ended.

Top module: `mdio_c45_master`

## Requirements
- R1: An accepted request produces exactly 65 MDC rising edges: 64 frame bits followed by one idle bit. `busy` is high from the clock after acceptance until the idle bit ends.
- R2: Frame bits 0..31 are driven as 1 (preamble). Bits 32..33 are driven as 0 (start-of-frame code 00).
- R3: Bits 34..35 carry `op` MSB first, with 00 = address, 01 = write and 11 = read. A request with `op` = 10 is dropped: `busy`, `mdc` and `mdio_oe` stay low.
- R4: Bits 36..40 carry `port_addr` and bits 41..45 carry `dev_addr`, each MSB first and driven.
- R5: Turnaround bits 46..47 are driven 1 then 0 for address and write frames. They are released (`mdio_oe` = 0) for read frames.
- R6: Bits 48..63 carry `payload` MSB first, driven, for address and write frames. For read frames the line is released and `mdio_in` is sampled on each MDC rising edge, MSB first, into `rd_data`. Address and write frames leave `rd_data` unchanged.
- R7: MDC has a period of 2*HALF_DIV system clocks and is low while idle. `mdio_oe` and `mdio_out` change only at an MDC falling edge or at acceptance, so they stay stable while MDC is high.
- R8: `done` is high for exactly one system clock, just after the falling MDC edge that ends bit 63. At that moment `busy` is still high and `rd_data` holds the final value.
- R9: A `start` pulse while `busy` is high is ignored. It neither alters the frame in progress nor queues another one.
- R10: During the idle bit (bit 64) and after reset, `mdio_oe` is low. Reset clears `busy`, `done`, `mdc` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| op | input | 2 | Operation: 00 address, 01 write, 11 read |
| port_addr | input | 5 | Port address field |
| dev_addr | input | 5 | Device address field |
| payload | input | 16 | Register address or write data |
| mdio_in | input | 1 | Sampled MDIO line |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_out | output | 1 | MDIO output data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse after the last data bit |
| rd_data | output | 16 | Data collected by the last read frame |

## Verification
A wrong bit counter or a slipped shift register moves a field against its neighbours. The bench decodes every MDC rising edge against an independently built frame, so the field that went wrong is flagged within the same frame. A wrong read/write flag appears as a driven turnaround on a read, or a released one on a write, within 47 bit times of acceptance. A divider fault shows up in the measured MDC period or in the total edge count before `busy` falls. A start that leaks through while busy shows as extra edges, or as a new transaction after the frame ends.

// File: rtl/mdio_c45_master.sv
module mdio_c45_master #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [4:0]  port_addr,
  input  logic [4:0]  dev_addr,
  input  logic [15:0] payload,
  input  logic        mdio_in,
  output logic        mdc,
  output logic        mdio_oe,
  output logic        mdio_out,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic [6:0]    bitn;
  logic [63:0]   sr;
  logic          is_rd;

  wire accept   = start && !busy && (op != 2'b10);
  wire in_data  = (bitn >= 7'd48) && (bitn < 7'd64);
  wire [63:0] frame = {32'hFFFF_FFFF, 2'b00, op, port_addr, dev_addr,
                       (op == 2'b11) ? 2'b00 : 2'b10, payload};

  assign mdio_oe  = busy && (bitn < 7'd46 || (!is_rd && bitn < 7'd64));
  assign mdio_out = mdio_oe & sr[63];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      sr      <= '0;
      is_rd   <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (accept) begin
          busy  <= 1'b1;
          sr    <= frame;
          bitn  <= '0;
          cnt   <= '0;
          mdc   <= 1'b0;
          is_rd <= (op == 2'b11);
        end
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (is_rd && in_data) rd_data <= {rd_data[14:0], mdio_in};
        end else begin
          sr <= {sr[62:0], 1'b0};
          if (bitn == 7'd63) done <= 1'b1;
          if (bitn == 7'd64) busy <= 1'b0;
          else bitn <= bitn + 7'd1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       mdio_out,
  input logic       busy,
  input logic       done
);
  a_r7_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_oe) && $stable(mdio_out)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  a_r3_reject_code: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'b10) |=> !busy);
endmodule

bind mdio_c45_master mdio_c45_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mdc(mdc),
  .mdio_oe(mdio_oe), .mdio_out(mdio_out), .busy(busy), .done(done)
);

// File: tb/mdio_c45_master_tb.sv
module mdio_c45_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mdio_in = 1'b1;
  logic [1:0]  op = '0;
  logic [4:0]  prt = '0, dev = '0;
  logic [15:0] wdata = '0;
  logic [15:0] last_rd = '0;
  wire mdc, mdio_oe, mdio_out, busy, done;
  wire [15:0] rd_data;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_c45_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .port_addr(prt),
    .dev_addr(dev), .payload(wdata), .mdio_in(mdio_in), .mdc(mdc),
    .mdio_oe(mdio_oe), .mdio_out(mdio_out), .busy(busy), .done(done),
    .rd_data(rd_data));

  // {op, port, dev, payload, phy read data}
  localparam logic [43:0] VEC [5] = '{
    {2'b00, 5'h15, 5'h01, 16'hA5C3, 16'h0000},
    {2'b01, 5'h00, 5'h1F, 16'hFFFF, 16'h0000},
    {2'b11, 5'h1F, 5'h00, 16'h1234, 16'h8001},
    {2'b11, 5'h0A, 5'h07, 16'hFFFF, 16'h3C5A},
    {2'b01, 5'h11, 5'h0E, 16'h0000, 16'hFFFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fld(input int j);
    if (j < 34) return 0;
    if (j < 36) return 1;
    if (j < 46) return 2;
    if (j < 48) return 3;
    if (j < 64) return 4;
    return 5;
  endfunction

  task automatic run_frame(input logic [1:0] o, input logic [4:0] p, input logic [4:0] d,
                           input logic [15:0] w, input logic [15:0] phy);
    logic [63:0] e;
    logic [15:0] rd_at_done;
    logic pm, eoe, eout;
    bit rd;
    int bad[6];
    int rises, cyc, done_n, done_at, r0, r1;
    rd = (o == 2'b11);
    e = {32'hFFFF_FFFF, 2'b00, o, p, d, rd ? 2'b00 : 2'b10, w};
    foreach (bad[i]) bad[i] = 0;
    rises = 0; cyc = 0; done_n = 0; done_at = -1; r0 = -1; r1 = -1;
    pm = 1'b0; rd_at_done = '0;
    @(negedge clk); op = o; prt = p; dev = d; wdata = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy && cyc < 5000) begin
      if (cyc == 40) begin start = 1'b1; op = 2'b00; prt = ~p; dev = ~d; wdata = ~w; end
      if (cyc == 41) start = 1'b0;
      if (done) begin done_n++; done_at = rises; rd_at_done = rd_data; end
      if (mdc && !pm) begin
        eoe  = (rises < 64) && (rises < 46 || !rd);
        eout = (rises < 64) ? e[63-rises] : 1'b0;
        if (mdio_oe !== eoe || (eoe && mdio_out !== eout)) bad[fld(rises)]++;
        if (rises == 0) r0 = cyc;
        if (rises == 1) r1 = cyc;
        rises++;
        mdio_in = (rises >= 48 && rises < 64) ? phy[63-rises] : 1'b1;
      end
      pm = mdc;
      @(negedge clk); cyc++;
    end
    check(cyc < 5000, "R1 frame ends", cyc, 5000);
    check(rises == 65, "R1 MDC rising edges", rises, 65);
    check(bad[0] == 0, "R2 preamble and start code bits", bad[0], 0);
    check(bad[1] == 0, "R3 op field bits", bad[1], 0);
    check(bad[2] == 0, "R4 port/device address bits", bad[2], 0);
    check(bad[3] == 0, "R5 turnaround bits", bad[3], 0);
    check(bad[4] == 0, "R6 data field bits", bad[4], 0);
    check(bad[5] == 0, "R10 idle bit released", bad[5], 0);
    check(r1 - r0 == 2*HALF, "R7 MDC period", r1 - r0, 2*HALF);
    check(done_n == 1, "R8 done pulse count", done_n, 1);
    check(done_at == 64, "R8 done after bit 63", done_at, 64);
    if (rd) last_rd = phy;
    check(rd_at_done === last_rd, "R6 rd_data at done", rd_at_done, last_rd);
    repeat (4*HALF) @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R9 start while busy not queued", {busy, mdc, mdio_oe}, 0);
  endtask

  initial begin
    #(CLK_PERIOD*190000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int stray;
    repeat (5) @(negedge clk);
    check(!busy && !done && !mdc && !mdio_oe && rd_data == 16'h0, "R10 reset state",
          {busy, done, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    op = 2'b10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    stray = 0;
    for (int k = 0; k < 20; k++) begin
      if (busy || mdc || mdio_oe) stray++;
      @(negedge clk);
    end
    check(stray == 0, "R3 op 10 rejected", stray, 0);
    for (int i = 0; i < 5; i++)
      run_frame(VEC[i][43:42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule